// File: doc/BRIEF.md
# System-Control Coprocessor Register Bank

This block holds the system-control registers of a 64-bit processor core. The core reaches them through move-to and move-from transfers. A write selects a slot with a register index and presents 64-bit data. A read selects a slot and returns 64-bit data one clock later, marked by a valid strobe.

Each slot applies its own merge rule when it is written. Some slots mask the incoming value. Some keep part of their old contents. Some ignore writes entirely. Slots that have no register behind them return a shared holding register, which captures the data of the most recent write to any index.

The bank also contains three pieces of live state:
- a free-running Count register that advances every second clock;
- a Random register that counts down between 31 and the Wired value;
- a timer interrupt flag. It is raised when Count matches Compare, it is cleared by writing Compare, and it is visible both on a port and in bit 15 of Cause.

Top module: `sysctl_regbank`

## Requirements
- R1: After a synchronous reset the reads return these values: Count 0x5000, Cause 0x5C, Context 0x7FFFF0, PRId 0xB22, Config 0x7006E463, Status 0x34000000, EPC (14), BadVAddr (8) and ErrorEPC (30) all ones, and Index (0) zero. Random starts at 31.
- R2: A read strobe in cycle n gives rd_valid=1 and the read data in cycle n+1. rd_valid is 0 in the cycle after a cycle with no read strobe. A read issued in the same cycle as a write returns the old contents.
- R3: Every write captures its data in a holding register. Reads of indices 7, 21, 22, 23, 24, 25 and 31 return that holding register.
- R4: Indices 32 to 63 read as zero. A write to them updates only the holding register.
- R5: Masked slots store written data ANDed with a fixed mask: Index (0) 0x8000003F, EntryLo0/EntryLo1 (2/3) 0x3FFFFFFF, PageMask (5) 0x1FFE000, Wired (6) 0x3F, EntryHi (10) 0xC00000FFFFFFE0FF, Status (12) 0xFFF7FFFF zero-extended, ECC (26) 0xFF.
- R6: A write to Context (4) replaces bits 63..23 and keeps bits 22..0. A write to XContext (20) replaces bits 63..33 and keeps bits 32..0.
- R7: A write to Config (16) becomes (data & 0x0F00800F) | (old & 0xF0FF7FF0). A write to LLAddr (17) replaces bits 31..0 and keeps bits 63..32.
- R8: Writes to Random (1), BadVAddr (8), PRId (15) and CacheErr (27) leave the stored value unchanged.
- R9: A write to Cause (13) sets Cause to old & 0x0FFFFCFF and ignores the data. Bit 15 of a Cause read is the timer interrupt flag.
- R10: A write to Count (9) loads the data. Count then holds for two clocks per step, so reads in the following cycles return V, V, V+1, V+1 and so on.
- R11: When Count equals Compare (11), timer_irq rises in the next cycle. It stays high until Compare is written, and it is 0 in the cycle after a Compare write.
- R12: Each clock, Random becomes 31 if its value is at or below Wired, and otherwise decreases by one.
- R13: EPC (14), WatchLo/WatchHi (18/19), TagLo/TagHi (28/29) and ErrorEPC (30) store all 64 written bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Move-to strobe |
| rd_en | input | 1 | Move-from strobe |
| idx | input | IDX_W (6) | Register index; values above 31 select nothing |
| wr_data | input | DW (64) | Write data |
| rd_data | output | DW (64) | Registered read data |
| rd_valid | output | 1 | rd_data holds the result of the previous cycle's read |
| timer_irq | output | 1 | Count/Compare match flag (Cause bit 15) |

## Verification
The assertions assume that wr_en and rd_en are always 0 or 1, and that idx is stable whenever a strobe is high. The Random and Count step properties also assume that no write to Random's or Count's own index is treated as a load of Random. The stimulus drives every strobe and index on the falling edge, and issues at most one read and one write per cycle. It steps Count and Compare only through their own indices, and keeps Compare away from values that Count could reach within the run. This keeps the interrupt deterministic: it fires only where the bench arranges a match.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DW   = 64;
  localparam int NREG = 32;

  localparam logic [4:0] RX_INDEX  = 5'd0;
  localparam logic [4:0] RX_RAND   = 5'd1;
  localparam logic [4:0] RX_ELO0   = 5'd2;
  localparam logic [4:0] RX_ELO1   = 5'd3;
  localparam logic [4:0] RX_CTX    = 5'd4;
  localparam logic [4:0] RX_PMASK  = 5'd5;
  localparam logic [4:0] RX_WIRED  = 5'd6;
  localparam logic [4:0] RX_BADVA  = 5'd8;
  localparam logic [4:0] RX_COUNT  = 5'd9;
  localparam logic [4:0] RX_EHI    = 5'd10;
  localparam logic [4:0] RX_CMP    = 5'd11;
  localparam logic [4:0] RX_STAT   = 5'd12;
  localparam logic [4:0] RX_CAUSE  = 5'd13;
  localparam logic [4:0] RX_EPC    = 5'd14;
  localparam logic [4:0] RX_PRID   = 5'd15;
  localparam logic [4:0] RX_CFG    = 5'd16;
  localparam logic [4:0] RX_LLA    = 5'd17;
  localparam logic [4:0] RX_XCTX   = 5'd20;
  localparam logic [4:0] RX_ECC    = 5'd26;
  localparam logic [4:0] RX_CERR   = 5'd27;
  localparam logic [4:0] RX_ERREPC = 5'd30;

  localparam logic [DW-1:0] COUNT_INIT = 64'h5000;
  localparam int            IRQ_BIT    = 15;

  function automatic logic [DW-1:0] reset_value(input logic [4:0] i);
    case (i)
      RX_CAUSE:                    return 64'h5C;
      RX_CTX:                      return 64'h007F_FFF0;
      RX_PRID:                     return 64'hB22;
      RX_CFG:                      return 64'h7006_E463;
      RX_STAT:                     return 64'h3400_0000;
      RX_EPC, RX_BADVA, RX_ERREPC: return '1;
      default:                     return '0;
    endcase
  endfunction

  function automatic logic is_hole(input logic [4:0] i);
    return (i == 5'd7) || (i >= 5'd21 && i <= 5'd25) || (i == 5'd31);
  endfunction
endpackage

// File: rtl/sysctl_wmerge.sv
module sysctl_wmerge
  import sysctl_pkg::*;
(
  input  logic [4:0]    sel,
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] new_val,
  output logic          store,
  output logic [DW-1:0] merged
);
  always_comb begin
    store  = 1'b1;
    merged = new_val;
    case (sel)
      RX_INDEX:         merged = new_val & 64'h0000_0000_8000_003F;
      RX_ELO0, RX_ELO1: merged = new_val & 64'h0000_0000_3FFF_FFFF;
      RX_CTX:           merged = (new_val & 64'hFFFF_FFFF_FF80_0000) |
                                 (old_val & 64'h0000_0000_007F_FFFF);
      RX_PMASK:         merged = new_val & 64'h0000_0000_01FF_E000;
      RX_WIRED:         merged = new_val & 64'h0000_0000_0000_003F;
      RX_EHI:           merged = new_val & 64'hC000_00FF_FFFF_E0FF;
      RX_STAT:          merged = new_val & 64'h0000_0000_FFF7_FFFF;
      RX_CAUSE:         merged = old_val & 64'h0000_0000_0FFF_FCFF;
      RX_CFG:           merged = (new_val & 64'h0000_0000_0F00_800F) |
                                 (old_val & 64'h0000_0000_F0FF_7FF0);
      RX_LLA:           merged = {old_val[63:32], new_val[31:0]};
      RX_XCTX:          merged = (new_val & 64'hFFFF_FFFE_0000_0000) |
                                 (old_val & 64'h0000_0001_FFFF_FFFF);
      RX_ECC:           merged = new_val & 64'h0000_0000_0000_00FF;
      RX_RAND, RX_BADVA, RX_COUNT, RX_CMP, RX_PRID, RX_CERR: store = 1'b0;
      default:          store = !is_hole(sel);
    endcase
  end
endmodule

// File: rtl/sysctl_timer.sv
module sysctl_timer
  import sysctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_count,
  input  logic          ld_cmp,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] count_q,
  output logic [DW-1:0] cmp_q,
  output logic          irq_q
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= COUNT_INIT;
      phase_q <= 1'b0;
      cmp_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (ld_count) begin
        count_q <= din;
        phase_q <= 1'b0;
      end else begin
        phase_q <= ~phase_q;
        if (phase_q) count_q <= count_q + 1'b1;
      end
      if (ld_cmp) begin
        cmp_q <= din;
        irq_q <= 1'b0;
      end else if (count_q == cmp_q) begin
        irq_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sysctl_random.sv
module sysctl_random #(
  parameter int RW  = 6,
  parameter int TOP = 31
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] floor_val,
  output logic [RW-1:0] rnd_q
);
  localparam logic [RW-1:0] TOPV = RW'(TOP);

  always_ff @(posedge clk) begin
    if (rst)                    rnd_q <= TOPV;
    else if (rnd_q <= floor_val) rnd_q <= TOPV;
    else                        rnd_q <= rnd_q - 1'b1;
  end
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int RND_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  output logic             timer_irq
);
  localparam int SEL_W = $clog2(NREG);

  logic [SEL_W-1:0] sel;
  logic             beyond;
  logic [DW-1:0]    regs [NREG];
  logic [DW-1:0]    latch_q;
  logic [DW-1:0]    count_q, cmp_q, merged, rd_next;
  logic             store, irq_q;
  logic [RND_W-1:0] rand_q, wired_q;

  assign sel     = idx[SEL_W-1:0];
  assign beyond  = |idx[IDX_W-1:SEL_W];
  assign wired_q = regs[RX_WIRED][RND_W-1:0];

  sysctl_wmerge u_merge (
    .sel(sel), .old_val(regs[sel]), .new_val(wr_data),
    .store(store), .merged(merged)
  );

  sysctl_timer u_timer (
    .clk(clk), .rst(rst),
    .ld_count(wr_en && !beyond && sel == RX_COUNT),
    .ld_cmp(wr_en && !beyond && sel == RX_CMP),
    .din(wr_data), .count_q(count_q), .cmp_q(cmp_q), .irq_q(irq_q)
  );

  sysctl_random #(.RW(RND_W), .TOP(31)) u_rand (
    .clk(clk), .rst(rst), .floor_val(wired_q), .rnd_q(rand_q)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam logic [DW-1:0] RV = reset_value(5'(g));
    always_ff @(posedge clk) begin
      if (rst) regs[g] <= RV;
      else if (wr_en && !beyond && store && sel == SEL_W'(g)) regs[g] <= merged;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        latch_q <= '0;
    else if (wr_en) latch_q <= wr_data;
  end

  always_comb begin
    if (beyond)                rd_next = '0;
    else if (is_hole(sel))     rd_next = latch_q;
    else if (sel == RX_RAND)   rd_next = DW'(rand_q);
    else if (sel == RX_COUNT)  rd_next = count_q;
    else if (sel == RX_CMP)    rd_next = cmp_q;
    else if (sel == RX_CAUSE) begin
      rd_next          = regs[RX_CAUSE];
      rd_next[IRQ_BIT] = irq_q;
    end else                   rd_next = regs[sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end

  assign timer_irq = irq_q;
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
  parameter int IDX_W = 6,
  parameter int DW    = 64,
  parameter int RND_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [IDX_W-1:0] idx,
  input logic [DW-1:0]    rd_data,
  input logic             rd_valid,
  input logic             timer_irq,
  input logic [DW-1:0]    count_q,
  input logic [DW-1:0]    cmp_q,
  input logic [RND_W-1:0] rand_q,
  input logic [RND_W-1:0] wired_q
);
  logic cmp_wr, cnt_wr;
  assign cmp_wr = wr_en && idx == IDX_W'(11);
  assign cnt_wr = wr_en && idx == IDX_W'(9);

  AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (rst) rd_en |=> rd_valid); // R2
  AST_RD_IDLE_NEXT: assert property (@(posedge clk) disable iff (rst) !rd_en |=> !rd_valid); // R2
  AST_HIGH_IDX_ZERO: assert property (@(posedge clk) disable iff (rst) (rd_en && idx > IDX_W'(31)) |=> rd_data == '0); // R4
  AST_CMP_WR_CLEARS: assert property (@(posedge clk) disable iff (rst) cmp_wr |=> !timer_irq); // R11
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst) (timer_irq && !cmp_wr) |=> timer_irq); // R11
  AST_IRQ_ON_MATCH: assert property (@(posedge clk) disable iff (rst) (count_q == cmp_q && !cmp_wr) |=> timer_irq); // R11
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst) !cnt_wr |=> (count_q - $past(count_q)) <= DW'(1)); // R10
  AST_RAND_DOWN: assert property (@(posedge clk) disable iff (rst) (rand_q > wired_q) |=> rand_q == $past(rand_q) - 1'b1); // R12
  AST_RAND_WRAP: assert property (@(posedge clk) disable iff (rst) (rand_q <= wired_q) |=> rand_q == RND_W'(31)); // R12
endmodule

bind sysctl_regbank sysctl_regbank_chk #(.IDX_W(IDX_W), .DW(64), .RND_W(RND_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .idx(idx),
  .rd_data(rd_data), .rd_valid(rd_valid), .timer_irq(timer_irq),
  .count_q(count_q), .cmp_q(cmp_q), .rand_q(rand_q), .wired_q(wired_q)
);

// File: tb/sim_sysctl_regbank.sv
module sim_sysctl_regbank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  idx = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic        rd_valid, timer_irq;

  int    checks = 0, failures = 0;
  bit    done = 1'b0;
  logic [63:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  sysctl_regbank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .idx(idx),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid), .timer_irq(timer_irq)
  );

  task automatic op_read(input int i, input logic [63:0] e, input string t);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; idx = 6'(i);
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic op_write(input int i, input logic [63:0] d);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b1; idx = 6'(i); wr_data = d;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
    end
  endtask

  task automatic check_val(input string t, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", t, a, e);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) check_val("R2 unexpected rd_valid", 64'd1, 64'd0);
      else check_val(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_val("R2 rd_valid low in reset", {63'd0, rd_valid}, 64'd0);
    check_val("R11 irq low in reset", {63'd0, timer_irq}, 64'd0);
    rst = 1'b0;
    // R1/R12: timing-exact reads right after reset release
    op_read(9, 64'h5000, "R1 count reset");
    op_read(1, 64'd29, "R12 random after two steps");
    op_write(6, 64'd28);
    op_read(1, 64'd27, "R12 random step");
    op_read(1, 64'd31, "R12 random wrap");
    op_read(1, 64'd30, "R12 random after wrap");
    op_read(1, 64'd29, "R12 random down");
    op_read(1, 64'd28, "R12 random at wired");
    op_read(1, 64'd31, "R12 random wrap again");
    op_read(13, 64'h5C, "R1 cause reset");
    op_read(4, 64'h7FFFF0, "R1 context reset");
    op_read(15, 64'hB22, "R1 prid reset");
    op_read(16, 64'h7006E463, "R1 config reset");
    op_read(12, 64'h34000000, "R1 status reset");
    op_read(14, '1, "R1 epc reset");
    op_read(8, '1, "R1 badvaddr reset");
    op_read(30, '1, "R1 errorepc reset");
    op_read(0, 64'd0, "R1 index reset");
    // R5 masks
    op_write(0, '1);  op_read(0, 64'h8000003F, "R5 index mask");
    op_write(2, '1);  op_read(2, 64'h3FFFFFFF, "R5 entrylo0 mask");
    op_write(3, '1);  op_read(3, 64'h3FFFFFFF, "R5 entrylo1 mask");
    op_write(5, '1);  op_read(5, 64'h1FFE000, "R5 pagemask mask");
    op_write(6, '1);  op_read(6, 64'h3F, "R5 wired mask");
    op_write(10, '1); op_read(10, 64'hC00000FFFFFFE0FF, "R5 entryhi mask");
    op_write(12, '1); op_read(12, 64'hFFF7FFFF, "R5 status mask");
    op_write(26, '1); op_read(26, 64'hFF, "R5 ecc mask");
    // R6 partial writes
    op_write(4, '1);  op_read(4, 64'hFFFFFFFFFFFFFFF0, "R6 context ones");
    op_write(4, '0);  op_read(4, 64'h7FFFF0, "R6 context zero");
    op_write(20, '1); op_read(20, 64'hFFFFFFFE00000000, "R6 xcontext");
    // R7 merges
    op_write(16, '0); op_read(16, 64'h70066460, "R7 config zero");
    op_write(16, '1); op_read(16, 64'h7F06E46F, "R7 config ones");
    op_write(17, '1); op_read(17, 64'hFFFFFFFF, "R7 lladdr low");
    // R8 read-only (wired is now 63, so random is held at 31)
    op_write(15, '1); op_read(15, 64'hB22, "R8 prid ignored");
    op_write(8, '0);  op_read(8, '1, "R8 badvaddr ignored");
    op_write(27, '1); op_read(27, 64'd0, "R8 cacheerr ignored");
    op_write(1, '0);  op_read(1, 64'd31, "R8 random ignored");
    // R9 cause
    op_write(13, '1); op_read(13, 64'h5C, "R9 cause write data ignored");
    // R13 full-width
    op_write(14, 64'h0123456789ABCDEF); op_read(14, 64'h0123456789ABCDEF, "R13 epc");
    op_write(29, 64'hA5A5_5A5A_F00D_BEEF); op_read(29, 64'hA5A5_5A5A_F00D_BEEF, "R13 taghi");
    op_write(19, 64'h8000_0000_0000_0001); op_read(19, 64'h8000_0000_0000_0001, "R13 watchhi");
    // R3 latch, R2 read-during-write returns old
    op_write(18, 64'h1111_2222_3333_4444);
    op_read(7, 64'h1111_2222_3333_4444, "R3 hole 7");
    op_read(21, 64'h1111_2222_3333_4444, "R3 hole 21");
    op_read(31, 64'h1111_2222_3333_4444, "R3 hole 31");
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; idx = 6'd28; wr_data = 64'h77;
    exp_q.push_back(64'd0); tag_q.push_back("R2 read during write old value");
    op_read(28, 64'h77, "R2 value after write");
    // R4 high indices
    op_write(40, 64'hDEAD_BEEF_0000_0042);
    op_read(25, 64'hDEAD_BEEF_0000_0042, "R4 latch from high write");
    op_read(40, 64'd0, "R4 high index reads zero");
    op_read(8, '1, "R4 high write left slot 8 alone");
    // R10 count
    op_write(9, 64'h1000);
    op_read(9, 64'h1000, "R10 count load");
    op_read(9, 64'h1000, "R10 count hold");
    op_read(9, 64'h1001, "R10 count step");
    op_read(9, 64'h1001, "R10 count hold2");
    // R11 compare
    op_write(11, 64'h100);
    op_write(9, 64'hFE);
    idle(5);
    check_val("R11 no irq before match", {63'd0, timer_irq}, 64'd0);
    idle(1);
    check_val("R11 irq after match", {63'd0, timer_irq}, 64'd1);
    idle(4);
    check_val("R11 irq sticky", {63'd0, timer_irq}, 64'd1);
    op_read(13, 64'h805C, "R9 cause bit15 shows irq");
    op_read(11, 64'h100, "R11 compare readback");
    op_write(11, 64'd0);
    idle(1);
    check_val("R11 compare write clears", {63'd0, timer_irq}, 64'd0);
    idle(3);
    check_val("R2 scoreboard drained", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule